// File: doc/BRIEF.md
# Streaming Gradient Edge Detector

This block turns a raster-ordered stream of grayscale pixels into a binary edge map, taking in one pixel on every clock where the input is valid. Two line stores and a 3x3 register window build the neighbourhood of each pixel. Two programmable 3x3 kernels are applied to that window. By default one kernel responds to horizontal edges and the other to vertical edges. The magnitude of each response is clamped to the pixel range. The larger of the two magnitudes is compared against a threshold supplied on a port.

Frame geometry is set by parameters. The start of each frame is marked on the input. The pipeline advances only on cycles where a pixel is accepted. A pause on the input therefore freezes every stage, and no data is lost. Each result leaves with start-of-frame and end-of-row markers attached. The result for a pixel appears a fixed number of accepted pixels after that pixel entered, namely one image row plus three.

Top module: `edge_grad_det`

## Requirements
- R1: After reset, `out_valid`, `out_sof` and `out_eol` are 0 and `out_pix` is 0.
- R2: Let p be the raster index of a pixel within its frame, and IMG_W the row width. The result for index p is presented with `out_valid` high in the cycle that follows the clock edge accepting index p+IMG_W+3. One frame of IMG_W*IMG_H inputs yields exactly IMG_W*IMG_H results, in raster order.
- R3: While `in_valid` is low, no stage advances. On the next cycle `out_valid` is 0 and `out_pix` is unchanged. Results are identical to those of an unpaused stream.
- R4: There are two kernels. Each has nine signed two's-complement taps of COEF_W bits. A tap is written when `coef_we` is high at a clock edge, addressed by `coef_sel` (0 = first kernel, 1 = second) and `coef_idx`. Tap index k = 3*row + col. Row 0 is the oldest image line of the window and col 0 is its leftmost (oldest) column.
- R5: Reset loads the first kernel with rows (-1,-2,-1),(0,0,0),(1,2,1) and the second with rows (-1,0,1),(-2,0,2),(-1,0,1).
- R6: Each kernel sum is taken as an absolute value and clamped to 255. The larger of the two clamped values is kept.
- R7: A kept value strictly greater than `thresh` gives `out_pix` = 255. A value equal to or below it gives 0.
- R8: Any pixel in the first or last row or column of the frame gives `out_pix` = 0, whatever its neighbourhood holds.
- R9: `out_sof` is high only with the result for row 0, column 0. `out_eol` is high only with results for column IMG_W-1. Both are high only while `out_valid` is high.
- R10: A tap write with `coef_idx` of 9 or above changes no tap.
- R11: An accepted pixel with `in_sof` high is taken as row 0, column 0, whatever position the stream had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present; the whole pipeline advances when high |
| in_pix | input | PIX_W | Grayscale input pixel |
| in_sof | input | 1 | Marks the first pixel of a frame |
| thresh | input | PIX_W | Edge threshold |
| coef_we | input | 1 | Kernel tap write strobe |
| coef_sel | input | 1 | Kernel select for the write |
| coef_idx | input | 4 | Tap index, row-major |
| coef_val | input | COEF_W | Signed tap value |
| out_valid | output | 1 | Result present |
| out_pix | output | PIX_W | Edge map pixel, 0 or 255 |
| out_sof | output | 1 | Result is row 0, column 0 |
| out_eol | output | 1 | Result is the last column of a row |

## Verification
The result for raster index p is due right after the edge that accepts index p+IMG_W+3. With out_sof, that means the bench must have fed exactly IMG_W+4 pixels of the frame when that flag shows. The bench counts the pixels it has accepted in each frame and compares that count at the moment out_sof appears. After each frame it streams IMG_W+3 filler pixels, which is exactly what drains the last result. Outputs are sampled on the falling edge. Paused cycles are checked one nanosecond after the rising edge they follow, where out_valid must already be low and out_pix unchanged.

// File: rtl/edge_grad_pkg.sv
package edge_grad_pkg;

   localparam int TAPS      = 9;
   localparam int KERNELS   = 2;
   localparam int TAP_IDX_W = $clog2(TAPS);

   // Reset value of a tap; kernel 0 reacts to horizontal edges, kernel 1 to vertical ones.
   function automatic int sobel_tap(input int kern, input int k);
      int row;
      int col;
      int w;
      row = k / 3;
      col = k % 3;
      if (kern == 0) begin
         w = (col == 1) ? 2 : 1;
         return (row == 0) ? -w : ((row == 2) ? w : 0);
      end
      w = (row == 1) ? 2 : 1;
      return (col == 0) ? -w : ((col == 2) ? w : 0);
   endfunction

endpackage

// File: rtl/egd_line_store.sv
module egd_line_store #(
   parameter int DEPTH = 64,
   parameter int PIX_W = 8,
   parameter int AW    = 6
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    col,
   input  logic [PIX_W-1:0] din,
   output logic [PIX_W-1:0] row_m1,
   output logic [PIX_W-1:0] row_m2
);

   logic [PIX_W-1:0] near_q [DEPTH];
   logic [PIX_W-1:0] far_q  [DEPTH];

   // read before write: the column seen here is one and two lines old
   assign row_m1 = near_q[col];
   assign row_m2 = far_q[col];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         near_q[col] <= din;
         far_q[col]  <= near_q[col];
      end
   end

endmodule

// File: rtl/egd_kernel_mac.sv
module egd_kernel_mac #(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 4,
   parameter int SUM_W  = 16,
   parameter int TAPS   = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic [TAPS*PIX_W-1:0]     win,
   input  logic [TAPS*COEF_W-1:0]    coef,
   output logic signed [SUM_W-1:0]   sum_q
);

   logic signed [SUM_W-1:0] acc;

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++) begin
         acc = acc
             + $signed({{(SUM_W-PIX_W){1'b0}}, win[k*PIX_W +: PIX_W]})
             * $signed({{(SUM_W-COEF_W){coef[k*COEF_W+COEF_W-1]}}, coef[k*COEF_W +: COEF_W]});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sum_q <= '0;
      else if (en) sum_q <= acc;
   end

endmodule

// File: rtl/egd_decide.sv
module egd_decide #(
   parameter int PIX_W = 8,
   parameter int SUM_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    in_v,
   input  logic                    border,
   input  logic                    sof,
   input  logic                    eol,
   input  logic signed [SUM_W-1:0] sum_a,
   input  logic signed [SUM_W-1:0] sum_b,
   input  logic [PIX_W-1:0]        thresh,
   output logic                    out_valid,
   output logic [PIX_W-1:0]        out_pix,
   output logic                    out_sof,
   output logic                    out_eol
);

   localparam logic [PIX_W-1:0] PIX_MAX = '1;

   function automatic logic [PIX_W-1:0] mag_sat(input logic signed [SUM_W-1:0] s);
      logic [SUM_W-1:0] m;
      m = s[SUM_W-1] ? SUM_W'(-s) : SUM_W'(s);
      return (m > SUM_W'(PIX_MAX)) ? PIX_MAX : m[PIX_W-1:0];
   endfunction

   logic [PIX_W-1:0] mag_a, mag_b, peak;
   logic             hit;

   always_comb begin
      mag_a = mag_sat(sum_a);
      mag_b = mag_sat(sum_b);
      peak  = (mag_a > mag_b) ? mag_a : mag_b;
      hit   = !border && (peak > thresh);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
      end else begin
         out_valid <= en && in_v;
         out_sof   <= en && in_v && sof;
         out_eol   <= en && in_v && eol;
         if (en) out_pix <= hit ? PIX_MAX : '0;
      end
   end

endmodule

// File: rtl/edge_grad_det.sv
module edge_grad_det
   import edge_grad_pkg::*;
#(
   parameter int IMG_W  = 64,
   parameter int IMG_H  = 48,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [PIX_W-1:0]     in_pix,
   input  logic                 in_sof,
   input  logic [PIX_W-1:0]     thresh,
   input  logic                 coef_we,
   input  logic                 coef_sel,
   input  logic [TAP_IDX_W-1:0] coef_idx,
   input  logic [COEF_W-1:0]    coef_val,
   output logic                 out_valid,
   output logic [PIX_W-1:0]     out_pix,
   output logic                 out_sof,
   output logic                 out_eol
);

   localparam int CW    = $clog2(IMG_W);
   localparam int RW    = $clog2(IMG_H);
   localparam int SUM_W = PIX_W + COEF_W + 4;
   localparam int FILL  = IMG_W + 1;
   localparam int FW    = $clog2(FILL + 1);

   if (IMG_W < 4)  begin : g_bad_w $error("IMG_W must be at least 4");  end
   if (IMG_H < 3)  begin : g_bad_h $error("IMG_H must be at least 3");  end
   if (COEF_W < 3) begin : g_bad_c $error("COEF_W must hold +/-2");     end

   logic adv;
   assign adv = in_valid;

   // ---------------- kernel taps ----------------
   logic [COEF_W-1:0] coef_q [KERNELS][TAPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int kn = 0; kn < KERNELS; kn++)
            for (int k = 0; k < TAPS; k++)
               coef_q[kn][k] <= COEF_W'(sobel_tap(kn, k));
      end else if (coef_we && (coef_idx < TAP_IDX_W'(TAPS))) begin
         coef_q[coef_sel][coef_idx] <= coef_val;
      end
   end

   // ---------------- raster position ----------------
   logic [CW-1:0] nc, pos_c, ctr_c;
   logic [RW-1:0] nr, pos_r, ctr_r;
   logic [FW-1:0] fill_q;
   logic          ctr_border;

   assign pos_c = in_sof ? '0 : nc;
   assign pos_r = in_sof ? '0 : nr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nc     <= '0;
         nr     <= '0;
         fill_q <= '0;
      end else if (adv) begin
         if (pos_c == CW'(IMG_W-1)) begin
            nc <= '0;
            nr <= (pos_r == RW'(IMG_H-1)) ? '0 : pos_r + 1'b1;
         end else begin
            nc <= pos_c + 1'b1;
            nr <= pos_r;
         end
         if (fill_q != FW'(FILL)) fill_q <= fill_q + 1'b1;
      end
   end

   // centre of the window after this pixel shifts in: one row and one column back
   always_comb begin
      if (pos_c == '0) begin
         ctr_c = CW'(IMG_W-1);
         ctr_r = (pos_r >= RW'(2)) ? pos_r - RW'(2) : pos_r + RW'(IMG_H-2);
      end else begin
         ctr_c = pos_c - 1'b1;
         ctr_r = (pos_r >= RW'(1)) ? pos_r - RW'(1) : RW'(IMG_H-1);
      end
      ctr_border = (ctr_c == '0) || (ctr_c == CW'(IMG_W-1)) ||
                   (ctr_r == '0) || (ctr_r == RW'(IMG_H-1));
   end

   // ---------------- line stores and window ----------------
   logic [PIX_W-1:0] row_m1, row_m2;
   logic [PIX_W-1:0] col_in [3];
   logic [PIX_W-1:0] win_q  [3][3];

   egd_line_store #(.DEPTH(IMG_W), .PIX_W(PIX_W), .AW(CW)) u_lines (
      .clk    (clk),
      .wr_en  (adv),
      .col    (pos_c),
      .din    (in_pix),
      .row_m1 (row_m1),
      .row_m2 (row_m2)
   );

   assign col_in[0] = row_m2;
   assign col_in[1] = row_m1;
   assign col_in[2] = in_pix;

   for (genvar r = 0; r < 3; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int c = 0; c < 3; c++) win_q[r][c] <= '0;
         end else if (adv) begin
            win_q[r][0] <= win_q[r][1];
            win_q[r][1] <= win_q[r][2];
            win_q[r][2] <= col_in[r];
         end
      end
   end

   logic s1_v, s1_border, s1_sof, s1_eol;
   logic s2_v, s2_border, s2_sof, s2_eol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {s1_v, s1_border, s1_sof, s1_eol} <= '0;
         {s2_v, s2_border, s2_sof, s2_eol} <= '0;
      end else if (adv) begin
         s1_v      <= (fill_q == FW'(FILL));
         s1_border <= ctr_border;
         s1_sof    <= (ctr_c == '0) && (ctr_r == '0);
         s1_eol    <= (ctr_c == CW'(IMG_W-1));
         s2_v      <= s1_v;
         s2_border <= s1_border;
         s2_sof    <= s1_sof;
         s2_eol    <= s1_eol;
      end
   end

   // ---------------- convolution ----------------
   logic [TAPS*PIX_W-1:0]   win_flat;
   logic [TAPS*COEF_W-1:0]  coef_flat [KERNELS];
   logic signed [SUM_W-1:0] sum_q     [KERNELS];

   for (genvar k = 0; k < TAPS; k++) begin : g_flat
      assign win_flat[k*PIX_W +: PIX_W] = win_q[k/3][k%3];
   end

   for (genvar kn = 0; kn < KERNELS; kn++) begin : g_kern
      for (genvar k = 0; k < TAPS; k++) begin : g_tap
         assign coef_flat[kn][k*COEF_W +: COEF_W] = coef_q[kn][k];
      end
      egd_kernel_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .SUM_W(SUM_W), .TAPS(TAPS)) u_mac (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (adv),
         .win   (win_flat),
         .coef  (coef_flat[kn]),
         .sum_q (sum_q[kn])
      );
   end

   // ---------------- magnitude, maximum, threshold ----------------
   egd_decide #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (adv),
      .in_v      (s2_v),
      .border    (s2_border),
      .sof       (s2_sof),
      .eol       (s2_eol),
      .sum_a     (sum_q[0]),
      .sum_b     (sum_q[1]),
      .thresh    (thresh),
      .out_valid (out_valid),
      .out_pix   (out_pix),
      .out_sof   (out_sof),
      .out_eol   (out_eol)
   );

endmodule

// File: rtl/edge_grad_det_chk.sv
module edge_grad_det_chk #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic [PIX_W-1:0] out_pix,
   input logic             out_sof,
   input logic             out_eol
);

   // R7
   binary_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_pix == '0 || out_pix == '1));

   // R3
   stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_pix));

   // R9
   flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof || out_eol) |-> out_valid);

   // R9
   sof_not_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> !out_eol);

endmodule

bind edge_grad_det edge_grad_det_chk #(.PIX_W(PIX_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_pix   (out_pix),
   .out_sof   (out_sof),
   .out_eol   (out_eol)
);

// File: tb/test_edge_grad_det.sv
module test_edge_grad_det;

   localparam int W = 8;
   localparam int H = 6;
   localparam int N = W * H;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_pix = '0;
   logic       in_sof = 1'b0;
   logic [7:0] thresh = '0;
   logic       coef_we = 1'b0;
   logic       coef_sel = 1'b0;
   logic [3:0] coef_idx = '0;
   logic [3:0] coef_val = '0;
   logic       out_valid;
   logic [7:0] out_pix;
   logic       out_sof;
   logic       out_eol;

   edge_grad_det #(.IMG_W(W), .IMG_H(H), .PIX_W(8), .COEF_W(4)) i_edge_grad_det (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .in_sof(in_sof),
      .thresh(thresh), .coef_we(coef_we), .coef_sel(coef_sel), .coef_idx(coef_idx),
      .coef_val(coef_val), .out_valid(out_valid), .out_pix(out_pix),
      .out_sof(out_sof), .out_eol(out_eol)
   );

   always #2 clk = ~clk;

   int n_checks = 0;
   int n_err = 0;
   int frame_acc = 0;
   int cap_idx = 0;
   int lat_seen = -1;
   int stall_bad = 0;
   int km [2][9];
   int img [H][W];
   int cap_pix [N];
   bit cap_sof [N];
   bit cap_eol [N];

   always @(negedge clk) begin
      if (out_valid) begin
         if (out_sof) begin
            cap_idx  = 0;
            lat_seen = frame_acc;
         end
         if (cap_idx < N) begin
            cap_pix[cap_idx] = out_pix;
            cap_sof[cap_idx] = out_sof;
            cap_eol[cap_idx] = out_eol;
         end
         cap_idx++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      int sob_a [9] = '{-1, -2, -1, 0, 0, 0, 1, 2, 1};
      int sob_b [9] = '{-1, 0, 1, -2, 0, 2, -1, 0, 1};
      rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; coef_we = 1'b0;
      for (int k = 0; k < 9; k++) begin
         km[0][k] = sob_a[k];
         km[1][k] = sob_b[k];
      end
      frame_acc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic load_coef(input int sel, input int idx, input int val);
      @(negedge clk);
      coef_we = 1'b1; coef_sel = sel[0]; coef_idx = idx[3:0]; coef_val = val[3:0];
      @(posedge clk);
      @(negedge clk);
      coef_we = 1'b0;
      if (idx < 9) km[sel][idx] = val;
   endtask

   task automatic drive_pix(input int p, input bit sof);
      @(negedge clk);
      in_valid = 1'b1; in_pix = p[7:0]; in_sof = sof;
      @(posedge clk);
      if (sof) frame_acc = 1;
      else     frame_acc++;
   endtask

   task automatic drive_gap();
      logic [7:0] held;
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; held = out_pix;
      @(posedge clk);
      #1;
      if (out_valid !== 1'b0 || out_pix !== held) stall_bad++;
   endtask

   function automatic int pix_at(input int pat, input int r, input int c, input int amp);
      case (pat)
         1:       return (c >= W/2) ? amp : 0;
         2:       return (r >= H/2) ? amp : 0;
         3:       return (r*53 + c*97 + r*c*11 + amp) & 255;
         default: return 0;
      endcase
   endfunction

   function automatic int clamp_abs(input int v);
      int a;
      a = (v < 0) ? -v : v;
      return (a > 255) ? 255 : a;
   endfunction

   function automatic int expect_at(input int r, input int c, input int th);
      int ga, gb, ma, mb, pk;
      if (r == 0 || r == H-1 || c == 0 || c == W-1) return 0;
      ga = 0; gb = 0;
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < 3; j++) begin
            ga += km[0][i*3+j] * img[r-1+i][c-1+j];
            gb += km[1][i*3+j] * img[r-1+i][c-1+j];
         end
      ma = clamp_abs(ga);
      mb = clamp_abs(gb);
      pk = (ma > mb) ? ma : mb;
      return (pk > th) ? 255 : 0;
   endfunction

   task automatic run_frame(input string req, input int pat, input int amp,
                            input int th, input int gap);
      int bad_pix, flag_bad, first_i, first_a, first_e;
      thresh = th[7:0];
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) img[r][c] = pix_at(pat, r, c, amp);
      cap_idx = 0; lat_seen = -1; stall_bad = 0;
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            drive_pix(img[r][c], (r == 0 && c == 0));
            if (gap > 0 && ((r*W + c) % gap) == gap-1) drive_gap();
         end
      for (int j = 0; j < W+3; j++) drive_pix(0, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      bad_pix = 0; flag_bad = 0; first_i = -1; first_a = 0; first_e = 0;
      for (int i = 0; i < N; i++) begin
         int e;
         e = expect_at(i / W, i % W, th);
         if (cap_pix[i] != e) begin
            if (first_i < 0) begin first_i = i; first_a = cap_pix[i]; first_e = e; end
            bad_pix++;
         end
         if (cap_sof[i] != (i == 0) || cap_eol[i] != ((i % W) == W-1)) flag_bad++;
      end
      check(bad_pix == 0, req, "edge map mismatches", bad_pix, 0);
      if (first_i >= 0)
         $display("  first mismatch at index %0d: got %0d want %0d", first_i, first_a, first_e);
      // R2
      check(cap_idx == N, "R2", "results per frame", cap_idx, N);
      // R2
      check(lat_seen == W+4, "R2", "accepted pixels when frame start emerged", lat_seen, W+4);
      // R9
      check(flag_bad == 0, "R9", "sof/eol flag errors", flag_bad, 0);
      if (gap > 0) begin
         // R3
         check(stall_bad == 0, "R3", "paused cycles with output activity", stall_bad, 0);
      end
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(out_pix === 8'd0, "R1", "out_pix after reset", out_pix, 0);
      check(out_sof === 1'b0 && out_eol === 1'b0, "R1", "flags after reset",
            {out_sof, out_eol}, 0);
   endtask

   task automatic t_vstep_above();
      do_reset();
      run_frame("R5", 1, 50, 199, 0);   // response 200 exceeds 199
   endtask

   task automatic t_vstep_equal();
      do_reset();
      run_frame("R7", 1, 50, 200, 0);   // response equal to threshold gives 0
   endtask

   task automatic t_hstep_sat();
      do_reset();
      run_frame("R6", 2, 100, 254, 0);  // 400 clamps to 255, above 254
   endtask

   task automatic t_border();
      do_reset();
      run_frame("R8", 3, 0, 0, 0);
   endtask

   task automatic t_stall();
      do_reset();
      run_frame("R3", 3, 17, 100, 3);
   endtask

   task automatic t_custom();
      do_reset();
      for (int k = 0; k < 9; k++) begin
         load_coef(0, k, 0);
         load_coef(1, k, 0);
      end
      load_coef(0, 0, 3);     // R4: top-left tap of first kernel
      load_coef(0, 4, -2);    // centre tap
      load_coef(1, 8, -8);    // bottom-right tap of second kernel
      run_frame("R4", 3, 5, 60, 0);
   endtask

   task automatic t_bad_index();
      do_reset();
      for (int k = 9; k < 16; k++) begin
         load_coef(0, k, 7);  // R10: ignored writes
         load_coef(1, k, 7);
      end
      run_frame("R10", 3, 9, 100, 0);
   endtask

   task automatic t_restart();
      do_reset();
      for (int j = 0; j < 6; j++) drive_pix(200, 1'b0);
      run_frame("R11", 3, 33, 90, 0);
   endtask

   initial begin
      t_reset();
      t_vstep_above();
      t_vstep_equal();
      t_hstep_sat();
      t_border();
      t_stall();
      t_custom();
      t_bad_index();
      t_restart();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule